// File: doc/BRIEF.md
# Clocked Preloaded Register File

This block is a small register file of thirty-two 32-bit words with two read ports and one write port, for the operand stage of a simple processor datapath. Each port has its own 5-bit address. Reads and the write all take effect on the rising clock edge. The two read results are captured into output registers, and they keep their values between edges.

A single enable input gates the whole block. While it is low, the block ignores every input: the storage does not change and the output registers keep their values. The storage starts from a fixed table of values at power-up, so a program can run on known operands without a loading phase. When the write address equals a read address in the same enabled cycle, the read returns the value stored before that edge. The new value is visible on the next enabled read.

Top module: `preload_regfile`

## Requirements
- R1: The block holds 32 words of 32 bits. Each port is addressed by a 5-bit unsigned index, and every index from 0 to 31 can be read on both read ports.
- R2: On an enabled rising edge, `rd_data_a` takes the word at `rd_addr_a` and `rd_data_b` takes the word at `rd_addr_b`. The value becomes visible just after that edge and stays there until the next enabled edge.
- R3: On an enabled rising edge, the word at `wr_addr` is replaced by `wr_data`. A later enabled read of that index returns the written value.
- R4: While `en` is low at a rising edge, neither read output changes, whatever the address and data inputs carry.
- R5: While `en` is low at a rising edge, no word is written. A later enabled read of the targeted index returns its earlier value.
- R6: If `wr_addr` equals a read address in an enabled cycle, that read output returns the value stored before the edge. The written value appears on the next enabled read of the index.
- R7: At power-up, index k holds, for k = 0 to 31 in order: 0, 5985, 12259, 482, 14245, 4820, 1847, 5260, 16179, 4766, 14928, 619, 15105, 9794, 7455, 9728, 9309, 12314, 12805, 10477, 1058, 6778, 8430, 5700, 13422, 13067, 1990, 921, 6020, 15768, 6093, 0 (decimal).
- R8: Before the first enabled edge, both read outputs are zero.
- R9: Index 0 and index 31 are ordinary writable words. Neither is tied to a constant.
- R10: When both read addresses are equal in an enabled cycle, both outputs show the same word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; only the rising edge is used |
| en | input | 1 | Global enable; low freezes storage and outputs |
| rd_addr_a | input | 5 | Index read into `rd_data_a` |
| rd_addr_b | input | 5 | Index read into `rd_data_b` |
| wr_addr | input | 5 | Index written from `wr_data` |
| wr_data | input | 32 | Word to store |
| rd_data_a | output | 32 | Registered read result, port A |
| rd_data_b | output | 32 | Registered read result, port B |

## Verification
A read and a write of the same index can fall on one enabled edge. The bench provokes this by driving `wr_addr` equal to `rd_addr_a` in one cycle and equal to `rd_addr_b` in another. The same-cycle output must show the prior contents, and a follow-up enabled read of that index must show the new word. The bench also sets the two read addresses equal, so that both output registers load from one storage word on the same edge, and checks that they agree.

// File: rtl/rfp_pkg.sv
package rfp_pkg;

   typedef enum logic {
      COLLIDE_OLD = 1'b0,
      COLLIDE_NEW = 1'b1
   } collide_e;

   function automatic logic [31:0] preset_word(input int unsigned idx);
      logic [31:0] v;
      case (idx)
         1:  v = 32'd5985;   2:  v = 32'd12259;  3:  v = 32'd482;
         4:  v = 32'd14245;  5:  v = 32'd4820;   6:  v = 32'd1847;
         7:  v = 32'd5260;   8:  v = 32'd16179;  9:  v = 32'd4766;
         10: v = 32'd14928;  11: v = 32'd619;    12: v = 32'd15105;
         13: v = 32'd9794;   14: v = 32'd7455;   15: v = 32'd9728;
         16: v = 32'd9309;   17: v = 32'd12314;  18: v = 32'd12805;
         19: v = 32'd10477;  20: v = 32'd1058;   21: v = 32'd6778;
         22: v = 32'd8430;   23: v = 32'd5700;   24: v = 32'd13422;
         25: v = 32'd13067;  26: v = 32'd1990;   27: v = 32'd921;
         28: v = 32'd6020;   29: v = 32'd15768;  30: v = 32'd6093;
         default: v = 32'd0;
      endcase
      return v;
   endfunction

endpackage

// File: rtl/rf_store.sv
module rf_store #(
   parameter int unsigned WORD_W  = 32,
   parameter int unsigned DEPTH   = 32,
   parameter bit          PRELOAD = 1'b1,
   localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
   input  logic                      clk,
   input  logic                      we,
   input  logic [ADDR_W-1:0]         wa,
   input  logic [WORD_W-1:0]         wd,
   output logic [DEPTH*WORD_W-1:0]   words
);
   typedef logic [WORD_W-1:0] image_t [DEPTH];

   function automatic image_t build_image();
      image_t img;
      for (int unsigned i = 0; i < DEPTH; i++) begin
         img[i] = PRELOAD ? WORD_W'(rfp_pkg::preset_word(i)) : '0;
      end
      return img;
   endfunction

   logic [WORD_W-1:0] mem [DEPTH] = build_image();

   always_ff @(posedge clk) begin
      if (we) begin
         mem[wa] <= wd;
      end
   end

   for (genvar g = 0; g < DEPTH; g++) begin : g_flat
      assign words[g*WORD_W +: WORD_W] = mem[g];
   end
endmodule

// File: rtl/rf_rdport.sv
module rf_rdport
   import rfp_pkg::*;
#(
   parameter int unsigned WORD_W  = 32,
   parameter int unsigned DEPTH   = 32,
   parameter collide_e    COLLIDE = COLLIDE_OLD,
   localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
   input  logic                    clk,
   input  logic                    en,
   input  logic [ADDR_W-1:0]       addr,
   input  logic [DEPTH*WORD_W-1:0] words,
   input  logic [ADDR_W-1:0]       wa,
   input  logic [WORD_W-1:0]       wd,
   output logic [WORD_W-1:0]       q
);
   logic [WORD_W-1:0] stored;
   logic [WORD_W-1:0] picked;
   logic [WORD_W-1:0] q_r = '0;

   always_comb stored = words[int'(addr)*WORD_W +: WORD_W];

   if (COLLIDE == COLLIDE_NEW) begin : g_bypass
      always_comb picked = (addr == wa) ? wd : stored;
   end else begin : g_plain
      logic [ADDR_W-1:0] unused_wa;
      logic [WORD_W-1:0] unused_wd;
      always_comb unused_wa = wa;
      always_comb unused_wd = wd;
      always_comb picked = stored;
   end

   always_ff @(posedge clk) begin
      if (en) begin
         q_r <= picked;
      end
   end

   assign q = q_r;
endmodule

// File: rtl/preload_regfile.sv
module preload_regfile
   import rfp_pkg::*;
#(
   parameter int unsigned WORD_W  = 32,
   parameter int unsigned DEPTH   = 32,
   parameter bit          PRELOAD = 1'b1,
   parameter collide_e    COLLIDE = COLLIDE_OLD,
   localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              en,
   input  logic [ADDR_W-1:0] rd_addr_a,
   input  logic [ADDR_W-1:0] rd_addr_b,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [WORD_W-1:0] wr_data,
   output logic [WORD_W-1:0] rd_data_a,
   output logic [WORD_W-1:0] rd_data_b
);
   localparam int unsigned NUM_RD = 2;

   if (DEPTH < 2 || DEPTH != (1 << ADDR_W)) begin : g_bad_depth
      $error("preload_regfile: DEPTH must be a power of two of at least 2");
   end
   if (WORD_W < 1) begin : g_bad_width
      $error("preload_regfile: WORD_W must be positive");
   end

   logic [DEPTH*WORD_W-1:0]          words;
   logic [NUM_RD-1:0][ADDR_W-1:0]    rd_addr_v;
   logic [NUM_RD-1:0][WORD_W-1:0]    rd_data_v;

   assign rd_addr_v[0] = rd_addr_a;
   assign rd_addr_v[1] = rd_addr_b;
   assign rd_data_a    = rd_data_v[0];
   assign rd_data_b    = rd_data_v[1];

   rf_store #(
      .WORD_W (WORD_W),
      .DEPTH  (DEPTH),
      .PRELOAD(PRELOAD)
   ) u_store (
      .clk  (clk),
      .we   (en),
      .wa   (wr_addr),
      .wd   (wr_data),
      .words(words)
   );

   for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
      rf_rdport #(
         .WORD_W (WORD_W),
         .DEPTH  (DEPTH),
         .COLLIDE(COLLIDE)
      ) u_port (
         .clk  (clk),
         .en   (en),
         .addr (rd_addr_v[p]),
         .words(words),
         .wa   (wr_addr),
         .wd   (wr_data),
         .q    (rd_data_v[p])
      );
   end
endmodule

// File: rtl/preload_regfile_chk.sv
module preload_regfile_chk #(
   parameter int unsigned WORD_W = 32,
   parameter int unsigned DEPTH  = 32,
   localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
   input logic              clk,
   input logic              en,
   input logic [ADDR_W-1:0] rd_addr_a,
   input logic [ADDR_W-1:0] rd_addr_b,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [WORD_W-1:0] wr_data,
   input logic [WORD_W-1:0] rd_data_a,
   input logic [WORD_W-1:0] rd_data_b
);
   logic [1:0] age = '0;
   always_ff @(posedge clk) begin
      if (age != 2'd3) age <= age + 2'd1;
   end

   // R4
   a_r4_hold: assert property (@(posedge clk) disable iff (age == 2'd0)
      !en |=> ($stable(rd_data_a) && $stable(rd_data_b)));

   // R10
   a_r10_ports_agree: assert property (@(posedge clk) disable iff (age == 2'd0)
      (en && rd_addr_a == rd_addr_b) |=> (rd_data_a == rd_data_b));

   // R3
   a_r3_write_then_read: assert property (@(posedge clk) disable iff (age == 2'd0)
      (en && $past(en) && rd_addr_a == $past(wr_addr) && wr_addr != rd_addr_a)
      |=> (rd_data_a == $past(wr_data, 2)));

   // R2
   a_r2_outputs_known: assert property (@(posedge clk) disable iff (age == 2'd0)
      !$isunknown({rd_data_a, rd_data_b}));
endmodule

bind preload_regfile preload_regfile_chk #(
   .WORD_W(WORD_W),
   .DEPTH (DEPTH)
) u_chk (.*);

// File: tb/preload_regfile_test.sv
`timescale 1ns/1ps
module preload_regfile_test;
   logic        clk = 1'b0;
   logic        en = 1'b0;
   logic [4:0]  rd_addr_a = '0, rd_addr_b = '0, wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data_a, rd_data_b;

   int checks = 0;
   int errors = 0;

   typedef struct {
      logic [31:0] a;
      logic [31:0] b;
      string       tag;
   } exp_t;
   exp_t q[$];

   logic [31:0] model [32];
   logic [31:0] hold_a = '0, hold_b = '0;

   always #2.5 clk = ~clk;

   preload_regfile uut (
      .clk(clk), .en(en),
      .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b),
      .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_data_a(rd_data_a), .rd_data_b(rd_data_b)
   );

   function automatic logic [31:0] table_val(int k);
      int t [32] = '{0, 5985, 12259, 482, 14245, 4820, 1847, 5260,
                     16179, 4766, 14928, 619, 15105, 9794, 7455, 9728,
                     9309, 12314, 12805, 10477, 1058, 6778, 8430, 5700,
                     13422, 13067, 1990, 921, 6020, 15768, 6093, 0};
      return 32'(t[k]);
   endfunction

   task automatic drive(bit e, int ra, int rb, int wa, logic [31:0] wd, string tag);
      exp_t it;
      @(negedge clk);
      en = e; rd_addr_a = 5'(ra); rd_addr_b = 5'(rb);
      wr_addr = 5'(wa); wr_data = wd;
      if (e) begin
         hold_a = model[ra];
         hold_b = model[rb];
         model[wa] = wd;
      end
      it.a = hold_a; it.b = hold_b; it.tag = tag;
      q.push_back(it);
   endtask

   // monitor
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (q.size() > 0) begin
            exp_t it;
            it = q.pop_front();
            checks++;
            if (rd_data_a !== it.a || rd_data_b !== it.b) begin
               errors++;
               $display("FAIL %s: a=%0d b=%0d expected a=%0d b=%0d",
                        it.tag, rd_data_a, rd_data_b, it.a, it.b);
            end
         end
      end
   end

   // watchdog
   initial begin
      repeat (20000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      for (int k = 0; k < 32; k++) model[k] = table_val(k);
      #1;
      checks++;
      if (rd_data_a !== 32'd0 || rd_data_b !== 32'd0) begin
         errors++;
         $display("FAIL R8: a=%0d b=%0d expected a=0 b=0", rd_data_a, rd_data_b);
      end
      // R4 R5: disabled cycles with a write attempt to index 5
      drive(0, 3, 4, 5, 32'hDEAD_0005, "R4 R5 disabled");
      drive(0, 9, 1, 5, 32'hDEAD_0006, "R4 R5 disabled");
      // R7 R1 R2: scan all indices, writing 0 into index 0 (unchanged)
      for (int i = 0; i < 32; i++) drive(1, i, 31 - i, 0, 32'd0, "R7 R1 R2 scan");
      // R5: index 5 still holds its power-up word
      drive(1, 5, 6, 0, 32'd0, "R5 no write while disabled");
      // R3 R9: write index 0 and index 31, then read them back
      drive(1, 2, 3, 0, 32'hDEAD_BEEF, "R3 R9 write 0");
      drive(1, 4, 5, 31, 32'h1234_5678, "R3 R9 write 31");
      drive(1, 0, 31, 10, 32'hA5A5_0010, "R3 R9 readback");
      drive(1, 10, 1, 1, 32'h0000_0111, "R3 readback 10");
      // R6: collisions on port A and port B
      drive(1, 7, 3, 7, 32'hC0DE_0007, "R6 port A old value");
      drive(1, 7, 8, 2, 32'h0000_0222, "R6 port A new value");
      drive(1, 12, 8, 8, 32'hC0DE_0008, "R6 port B old value");
      drive(1, 9, 8, 4, 32'h0000_0444, "R6 port B new value");
      drive(1, 13, 13, 13, 32'hC0DE_000D, "R6 R10 both ports collide");
      drive(1, 13, 13, 3, 32'h0000_0333, "R6 R10 both ports new");
      // R4: hold nonzero outputs while inputs change
      drive(0, 20, 21, 13, 32'hFFFF_FFFF, "R4 hold");
      drive(0, 0, 1, 7, 32'hEEEE_EEEE, "R4 hold");
      drive(1, 13, 7, 20, 32'h0000_0020, "R5 R3 after hold");
      drive(1, 20, 20, 0, 32'h0, "R10 same index");
      wait (q.size() == 0);
      @(negedge clk);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule